// File: doc/BRIEF.md
# Seeded Pattern Generator and Signature Compactor Paths

This block holds two serial test-data paths that can each be switched between a plain byte buffer and a self-test structure. The outgoing path normally queues up to two bytes and shifts them out one bit per shift tick. In generator mode it becomes a 32-bit linear-feedback pseudo-random source built from four byte-wide seed segments. The incoming path normally gathers serial bits into bytes and queues up to two of them. In compactor mode it becomes a 16-bit signature register that folds every incoming bit into its feedback.

A host loads seed bytes through one byte-wide write port with a segment address. For each test mode a stall enable can be set. While a mode is active with its stall enable set and some of that mode's seed segments are still unwritten, the block raises a clock-hold output that stops the test clock. While the hold is raised, neither path advances on shift ticks. Leaving a mode forgets which seeds were written, so every new entry into a mode has to be seeded again.

Top module: `ltp_seed_paths`

## Requirements
- R1: After reset, `sdo` is 0, `clk_hold` is 0 with all modes off, `tx_not_full` is 1, `rx_not_empty` is 0 and `sig_out` is 0.
- R2: In generator mode, a seed write to address k (0 to 3) loads bits [8k+7:8k] of the 32-bit generator register, and `sdo` shows bit 31 of that register.
- R3: With generator mode and its stall enable both high, `clk_hold` is 1 until seed writes have reached all four addresses 0 to 3.
- R4: Each generator advance shifts the register left by one and puts the XOR of bits 31, 21, 1 and 0 into bit 0 (taps of x^32+x^22+x^2+x+1).
- R5: In compactor mode, address 4 loads `sig_out[7:0]` and address 5 loads `sig_out[15:8]`. Seed writes to these addresses outside compactor mode are ignored.
- R6: With compactor mode and its stall enable both high, `clk_hold` is 1 until both addresses 4 and 5 have been written.
- R7: Each compactor advance computes fb = `sig_out[15]` XOR `sdi`, then shifts left with a 0 entering bit 0, then XORs 16'h1021 into the result when fb is 1.
- R8: A path advances only on a cycle where `shift_tick` is 1 and `clk_hold` is 0. Ticks taken while `clk_hold` is 1 change nothing in either path.
- R9: Whenever a mode input is low, that mode's seed-written record is cleared, so re-entering the mode with its stall enabled raises `clk_hold` again.
- R10: A seed write to a segment of the active mode takes priority over a shift tick in the same cycle: the byte is loaded and that register does not shift.
- R11: Outside generator mode, a write to address 0 queues a byte if fewer than two are queued, and otherwise is ignored. `sdo` presents the head byte LSB first, one bit per advance, and is 0 when the queue is empty. `tx_not_full` is 1 while fewer than two bytes are queued.
- R12: Outside compactor mode, each advance captures `sdi`, and every eight bits form a byte (first bit in bit 0) that is queued if fewer than two are queued and is dropped otherwise. `rx_not_empty` flags a queued byte, `rx_data` shows the oldest one, and `rx_pop` removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gen_mode | input | 1 | Outgoing path works as pattern generator |
| gen_hold_en | input | 1 | Stall the test clock until generator is seeded |
| cmp_mode | input | 1 | Incoming path works as signature compactor |
| cmp_hold_en | input | 1 | Stall the test clock until compactor is seeded |
| seed_we | input | 1 | Byte write strobe |
| seed_addr | input | 3 | Write target: 0-3 generator segments or outgoing queue, 4-5 compactor halves |
| seed_data | input | 8 | Write byte |
| shift_tick | input | 1 | One-bit shift request |
| sdi | input | 1 | Serial input bit |
| rx_pop | input | 1 | Remove oldest received byte |
| sdo | output | 1 | Serial output bit |
| clk_hold | output | 1 | Test clock must stay stopped |
| tx_not_full | output | 1 | Outgoing queue can accept a byte |
| rx_not_empty | output | 1 | A received byte is waiting |
| rx_data | output | 8 | Oldest received byte |
| sig_out | output | 16 | Compactor signature register |

## Verification
`clk_hold` is combinational from the mode inputs and the registered seed record, so it is checked one time step after the inputs are driven on a falling edge. Each write, tick or pop is held for exactly one rising edge, so `sdo`, `sig_out`, `rx_data` and both queue flags are due one edge after the stimulus and are sampled at the next falling edge. The generator and compactor sequences are compared bit by bit against bench models that step once per tick, and any shift taken during a hold shows up as a lasting mismatch.

// File: rtl/ltp_pkg.sv
package ltp_pkg;
    localparam int BYTE_W     = 8;
    localparam int FIFO_DEPTH = 2;

    typedef logic [BYTE_W-1:0]                   byte_t;
    typedef logic [$clog2(FIFO_DEPTH+1)-1:0]     fcnt_t;
    typedef logic [$clog2(BYTE_W)-1:0]           bitpos_t;
    typedef byte_t [FIFO_DEPTH-1:0]              fifo_t;
endpackage

// File: rtl/ltp_gen_path.sv
module ltp_gen_path
    import ltp_pkg::*;
#(
    parameter int                         SEGS   = 4,
    parameter int                         ADDR_W = 3,
    parameter logic [SEGS*BYTE_W-1:0]     TAPS   = 32'h8020_0003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode,
    input  logic              hold_en,
    input  logic              adv,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  byte_t             wdata,
    output logic              sdo,
    output logic              hold,
    output logic              tx_not_full
);
    localparam int W = SEGS * BYTE_W;

    typedef struct packed {
        logic [W-1:0]    lfsr;
        logic [SEGS-1:0] seeded;
        fifo_t           fifo;
        fcnt_t           cnt;
        bitpos_t         pos;
    } gen_st_t;

    gen_st_t q, d;
    logic    seg_hit;
    logic    pop;
    logic    push;
    fcnt_t   slot;

    always_comb begin
        d       = q;
        seg_hit = we && (addr < ADDR_W'(SEGS));
        pop     = 1'b0;
        push    = 1'b0;
        slot    = '0;
        if (!mode) begin
            d.seeded = '0;
        end
        if (mode) begin
            if (seg_hit) begin
                for (int k = 0; k < SEGS; k++) begin
                    if (addr == ADDR_W'(k)) begin
                        d.lfsr[k*BYTE_W +: BYTE_W] = wdata;
                        d.seeded[k]                = 1'b1;
                    end
                end
            end else if (adv) begin
                d.lfsr = {q.lfsr[W-2:0], ^(q.lfsr & TAPS)};
            end
        end else begin
            pop  = adv && (q.cnt != '0) && (q.pos == bitpos_t'(BYTE_W-1));
            push = we && (addr == '0) && (q.cnt < fcnt_t'(FIFO_DEPTH));
            slot = q.cnt - fcnt_t'(pop);
            if (adv && (q.cnt != '0)) begin
                d.pos = q.pos + bitpos_t'(1);
            end
            if (pop) begin
                for (int i = 0; i < FIFO_DEPTH-1; i++) begin
                    d.fifo[i] = q.fifo[i+1];
                end
            end
            if (push) begin
                for (int i = 0; i < FIFO_DEPTH; i++) begin
                    if (slot == fcnt_t'(i)) begin
                        d.fifo[i] = wdata;
                    end
                end
            end
            d.cnt = q.cnt - fcnt_t'(pop) + fcnt_t'(push);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign hold        = mode && hold_en && !(&q.seeded);
    assign sdo         = mode ? q.lfsr[W-1] : ((q.cnt != '0) && q.fifo[0][q.pos]);
    assign tx_not_full = (q.cnt < fcnt_t'(FIFO_DEPTH));
endmodule

// File: rtl/ltp_cmp_path.sv
module ltp_cmp_path
    import ltp_pkg::*;
#(
    parameter int                         SEGS   = 2,
    parameter int                         BASE   = 4,
    parameter int                         ADDR_W = 3,
    parameter logic [SEGS*BYTE_W-1:0]     POLY   = 16'h1021
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode,
    input  logic                     hold_en,
    input  logic                     adv,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        addr,
    input  byte_t                    wdata,
    input  logic                     sdi,
    input  logic                     rx_pop,
    output logic [SEGS*BYTE_W-1:0]   sig,
    output logic                     hold,
    output byte_t                    rx_data,
    output logic                     rx_not_empty
);
    localparam int W = SEGS * BYTE_W;

    typedef struct packed {
        logic [W-1:0]    sig;
        logic [SEGS-1:0] seeded;
        byte_t           sh;
        bitpos_t         nbits;
        fifo_t           fifo;
        fcnt_t           cnt;
    } cmp_st_t;

    cmp_st_t q, d;
    logic    seg_hit;
    logic    fb;
    logic    pop;
    logic    push;
    byte_t   assembled;
    fcnt_t   slot;

    always_comb begin
        d         = q;
        seg_hit   = we && (addr >= ADDR_W'(BASE)) && (addr < ADDR_W'(BASE + SEGS));
        fb        = q.sig[W-1] ^ sdi;
        pop       = 1'b0;
        push      = 1'b0;
        slot      = '0;
        assembled = {sdi, q.sh[BYTE_W-1:1]};
        if (!mode) begin
            d.seeded = '0;
        end
        if (mode) begin
            if (seg_hit) begin
                for (int k = 0; k < SEGS; k++) begin
                    if (addr == ADDR_W'(BASE + k)) begin
                        d.sig[k*BYTE_W +: BYTE_W] = wdata;
                        d.seeded[k]               = 1'b1;
                    end
                end
            end else if (adv) begin
                d.sig = {q.sig[W-2:0], 1'b0} ^ (fb ? POLY : '0);
            end
        end else begin
            pop  = rx_pop && (q.cnt != '0);
            push = adv && (q.nbits == bitpos_t'(BYTE_W-1)) && (q.cnt < fcnt_t'(FIFO_DEPTH));
            slot = q.cnt - fcnt_t'(pop);
            if (adv) begin
                d.sh    = assembled;
                d.nbits = q.nbits + bitpos_t'(1);
            end
            if (pop) begin
                for (int i = 0; i < FIFO_DEPTH-1; i++) begin
                    d.fifo[i] = q.fifo[i+1];
                end
            end
            if (push) begin
                for (int i = 0; i < FIFO_DEPTH; i++) begin
                    if (slot == fcnt_t'(i)) begin
                        d.fifo[i] = assembled;
                    end
                end
            end
            d.cnt = q.cnt - fcnt_t'(pop) + fcnt_t'(push);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sig          = q.sig;
    assign hold         = mode && hold_en && !(&q.seeded);
    assign rx_data      = q.fifo[0];
    assign rx_not_empty = (q.cnt != '0);
endmodule

// File: rtl/ltp_seed_paths.sv
module ltp_seed_paths
    import ltp_pkg::*;
#(
    parameter int                            GEN_SEGS = 4,
    parameter int                            CMP_SEGS = 2,
    parameter logic [GEN_SEGS*BYTE_W-1:0]    GEN_TAPS = 32'h8020_0003,
    parameter logic [CMP_SEGS*BYTE_W-1:0]    CMP_POLY = 16'h1021,
    localparam int                           ADDR_W   = $clog2(GEN_SEGS + CMP_SEGS),
    localparam int                           CMP_W    = CMP_SEGS * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gen_mode,
    input  logic              gen_hold_en,
    input  logic              cmp_mode,
    input  logic              cmp_hold_en,
    input  logic              seed_we,
    input  logic [ADDR_W-1:0] seed_addr,
    input  logic [7:0]        seed_data,
    input  logic              shift_tick,
    input  logic              sdi,
    input  logic              rx_pop,
    output logic              sdo,
    output logic              clk_hold,
    output logic              tx_not_full,
    output logic              rx_not_empty,
    output logic [7:0]        rx_data,
    output logic [CMP_W-1:0]  sig_out
);
    logic gen_hold;
    logic cmp_hold;
    logic adv;

    assign clk_hold = gen_hold | cmp_hold;
    assign adv      = shift_tick & ~clk_hold;

    ltp_gen_path #(
        .SEGS   (GEN_SEGS),
        .ADDR_W (ADDR_W),
        .TAPS   (GEN_TAPS)
    ) u_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (gen_mode),
        .hold_en     (gen_hold_en),
        .adv         (adv),
        .we          (seed_we),
        .addr        (seed_addr),
        .wdata       (seed_data),
        .sdo         (sdo),
        .hold        (gen_hold),
        .tx_not_full (tx_not_full)
    );

    ltp_cmp_path #(
        .SEGS   (CMP_SEGS),
        .BASE   (GEN_SEGS),
        .ADDR_W (ADDR_W),
        .POLY   (CMP_POLY)
    ) u_cmp (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode         (cmp_mode),
        .hold_en      (cmp_hold_en),
        .adv          (adv),
        .we           (seed_we),
        .addr         (seed_addr),
        .wdata        (seed_data),
        .sdi          (sdi),
        .rx_pop       (rx_pop),
        .sig          (sig_out),
        .hold         (cmp_hold),
        .rx_data      (rx_data),
        .rx_not_empty (rx_not_empty)
    );
endmodule

// File: rtl/ltp_seed_paths_chk.sv
module ltp_seed_paths_chk #(
    parameter int CMP_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gen_mode,
    input logic             gen_hold_en,
    input logic             cmp_mode,
    input logic             cmp_hold_en,
    input logic             seed_we,
    input logic             clk_hold,
    input logic             sdo,
    input logic [CMP_W-1:0] sig_out
);
    AST_HOLD_NEEDS_STALL_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        clk_hold |-> ((gen_mode && gen_hold_en) || (cmp_mode && cmp_hold_en))); // R3

    AST_HOLD_FREEZES_SIG: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_hold && !seed_we) |=> $stable(sig_out)); // R8

    AST_HOLD_FREEZES_SDO: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_hold && !seed_we) ##1 $stable(gen_mode) |-> $stable(sdo)); // R8

    AST_SIG_QUIET_OUT_OF_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_mode && !seed_we) |=> $stable(sig_out)); // R5
endmodule

bind ltp_seed_paths ltp_seed_paths_chk #(.CMP_W(CMP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .gen_mode    (gen_mode),
    .gen_hold_en (gen_hold_en),
    .cmp_mode    (cmp_mode),
    .cmp_hold_en (cmp_hold_en),
    .seed_we     (seed_we),
    .clk_hold    (clk_hold),
    .sdo         (sdo),
    .sig_out     (sig_out)
);

// File: tb/ltp_seed_paths_bench.sv
`timescale 1ns/1ps
module ltp_seed_paths_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        gen_mode, gen_hold_en, cmp_mode, cmp_hold_en;
    logic        seed_we;
    logic [2:0]  seed_addr;
    logic [7:0]  seed_data;
    logic        shift_tick, sdi, rx_pop;
    logic        sdo, clk_hold, tx_not_full, rx_not_empty;
    logic [7:0]  rx_data;
    logic [15:0] sig_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    ltp_seed_paths u_ltp_seed_paths (
        .clk(clk), .rst_n(rst_n), .gen_mode(gen_mode), .gen_hold_en(gen_hold_en),
        .cmp_mode(cmp_mode), .cmp_hold_en(cmp_hold_en), .seed_we(seed_we),
        .seed_addr(seed_addr), .seed_data(seed_data), .shift_tick(shift_tick),
        .sdi(sdi), .rx_pop(rx_pop), .sdo(sdo), .clk_hold(clk_hold),
        .tx_not_full(tx_not_full), .rx_not_empty(rx_not_empty),
        .rx_data(rx_data), .sig_out(sig_out)
    );

    function automatic logic [31:0] gen_next(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    function automatic logic [15:0] cmp_next(input logic [15:0] s, input logic b);
        logic [15:0] r;
        r = {s[14:0], 1'b0};
        if (s[15] ^ b) r = r ^ 16'h1021;
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; gen_mode = 0; gen_hold_en = 0; cmp_mode = 0; cmp_hold_en = 0;
        seed_we = 0; seed_addr = '0; seed_data = '0; shift_tick = 0; sdi = 0; rx_pop = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        seed_we = 1'b1; seed_addr = a; seed_data = v;
        @(negedge clk);
        seed_we = 1'b0;
    endtask

    task automatic tick(input logic b);
        shift_tick = 1'b1; sdi = b;
        @(negedge clk);
        shift_tick = 1'b0;
    endtask

    task automatic pop();
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 sdo", sdo, 0);
        chk("R1 clk_hold", clk_hold, 0);
        chk("R1 tx_not_full", tx_not_full, 1);
        chk("R1 rx_not_empty", rx_not_empty, 0);
        chk("R1 sig_out", sig_out, 0);
    endtask

    task automatic t_gen();
        logic [31:0] seed = 32'hC3A5_0F96;
        logic [31:0] m;
        do_reset();
        gen_mode = 1'b1; gen_hold_en = 1'b1;
        #1 chk("R3 hold before seeding", clk_hold, 1);
        for (int k = 0; k < 3; k++) begin
            wr(3'(k), seed[k*8 +: 8]);
            chk("R3 hold with partial seed", clk_hold, 1);
        end
        repeat (3) tick(1'b0);
        wr(3'd3, seed[31:24]);
        chk("R3 hold released", clk_hold, 0);
        chk("R2 sdo shows seed MSB", sdo, seed[31]);
        m = seed;
        for (int i = 0; i < 40; i++) begin
            chk(i < 8 ? "R2 seed segment order" : "R4 generator sequence (R8 no shift while held)", sdo, m[31]);
            tick(1'b0);
            m = gen_next(m);
        end
        seed_we = 1'b1; seed_addr = 3'd0; seed_data = 8'h5A; shift_tick = 1'b1;
        @(negedge clk);
        seed_we = 1'b0; shift_tick = 1'b0;
        m[7:0] = 8'h5A;
        for (int i = 0; i < 32; i++) begin
            chk("R10 write beats tick", sdo, m[31]);
            tick(1'b0);
            m = gen_next(m);
        end
        chk("R10 tx queue untouched by seed write", tx_not_full, 1);
        gen_mode = 1'b0;
        @(negedge clk);
        gen_mode = 1'b1;
        #1 chk("R9 hold after re-entry", clk_hold, 1);
        @(negedge clk);
        gen_mode = 1'b0; gen_hold_en = 1'b0;
        #1 chk("R11 sdo zero with empty queue", sdo, 0);
    endtask

    task automatic t_cmp();
        logic [31:0] pat = 32'hB7E1_5163;
        logic [15:0] m;
        do_reset();
        wr(3'd4, 8'h77);
        chk("R5 write ignored outside mode", sig_out, 16'h0000);
        cmp_mode = 1'b1; cmp_hold_en = 1'b1;
        #1 chk("R6 hold before seeding", clk_hold, 1);
        @(negedge clk);
        wr(3'd4, 8'h34);
        chk("R5 low seed byte", sig_out, 16'h0034);
        chk("R6 hold with one seed", clk_hold, 1);
        tick(1'b1);
        chk("R8 compactor frozen while held", sig_out, 16'h0034);
        wr(3'd5, 8'h12);
        chk("R5 high seed byte", sig_out, 16'h1234);
        chk("R6 hold released", clk_hold, 0);
        m = 16'h1234;
        for (int i = 0; i < 24; i++) begin
            tick(pat[i]);
            m = cmp_next(m, pat[i]);
            chk("R7 signature step", sig_out, m);
        end
        gen_mode = 1'b1; gen_hold_en = 1'b1;
        #1 chk("R8 generator stall holds clock", clk_hold, 1);
        tick(1'b1);
        chk("R8 compactor frozen by generator stall", sig_out, m);
        gen_mode = 1'b0; gen_hold_en = 1'b0;
        cmp_mode = 1'b0;
        @(negedge clk);
        cmp_mode = 1'b1;
        #1 chk("R9 compactor hold after re-entry", clk_hold, 1);
        cmp_mode = 1'b0; cmp_hold_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) tick(b[i]);
    endtask

    task automatic t_rx();
        logic [7:0] b = 8'h5D;
        do_reset();
        for (int i = 0; i < 8; i++) begin
            tick(b[i]);
            if (i == 6) chk("R12 empty before 8th bit", rx_not_empty, 0);
        end
        chk("R12 byte ready", rx_not_empty, 1);
        chk("R12 first byte", rx_data, 8'h5D);
        send_byte(8'hE2);
        send_byte(8'h19);
        chk("R12 head kept when full", rx_data, 8'h5D);
        pop();
        chk("R12 second byte after pop", rx_data, 8'hE2);
        chk("R12 still not empty", rx_not_empty, 1);
        pop();
        chk("R12 overflow byte dropped", rx_not_empty, 0);
    endtask

    task automatic t_tx();
        logic [15:0] pair = {8'h3C, 8'hA6};
        do_reset();
        wr(3'd0, 8'hA6);
        chk("R11 one queued", tx_not_full, 1);
        wr(3'd0, 8'h3C);
        chk("R11 full", tx_not_full, 0);
        wr(3'd0, 8'hFF);
        for (int i = 0; i < 16; i++) begin
            chk("R11 serial bit", sdo, pair[i]);
            tick(1'b0);
            if (i == 7) chk("R11 space after first byte", tx_not_full, 1);
        end
        for (int i = 0; i < 8; i++) begin
            chk("R11 write while full ignored", sdo, 0);
            tick(1'b0);
        end
        chk("R11 queue empty", tx_not_full, 1);
    endtask

    initial begin
        t_reset();
        t_gen();
        t_cmp();
        t_rx();
        t_tx();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule